// File: doc/BRIEF.md
# Floppy Controller Host Command Sequencer

This block is the part of a floppy disk controller that talks to the host processor. The host sees two byte ports: a status port and a data port. Through the data port it writes a command byte and its parameters, moves the sector bytes during execution, and reads back the result bytes. The block moves through four phases: idle, parameter collection, execution and result. Two status flags gate every data access. The ready flag (RQM) says the data port can be used now. The direction flag (DIO) says whether the next access is a read or a write.

During execution, the block raises a per-byte request (DRQ) for each byte. A read transfer takes the bytes from a small internal sector buffer. A write transfer stores them there. A scan transfer compares each host byte with the buffered disk byte. If the host leaves a request unserved for too long, the block aborts the transfer and reports an overrun. A seek-complete pulse from the drive side leaves a pending interrupt for that drive. The sense-interrupt command reads these back one drive at a time. The testbench fills the buffer through a load port, and a small table gives the parameter count for each command.

Top module: `fdc_host_seq`

## Requirements
- R1: After reset the status byte is 0x80 (ready set, direction clear) ORed with `seek_busy_i` in bits 3:0. Status bits are: bit7 ready, bit6 direction (1 = controller to host), bit5 execution (non-DMA) phase, bit4 controller busy.
- R2: A data-port write is accepted only when ready=1 and direction=0. A data-port read is accepted only when ready=1 and direction=1. A refused write changes no state. A refused or strobe-less data read returns 0xFF.
- R3: In idle, the first accepted write is the command, and its low 5 bits select the operation. Codes 0x03, 0x05, 0x06, 0x08, 0x11, 0x19 and 0x1D are known. Any other code goes straight to a one-byte result 0x80, with status 0xD0.
- R4: Read execution (0x06) starts right after the 8th parameter, with DRQ=1 and status 0xF0. Each accepted byte drops DRQ and ready at once. The next DRQ rises BYTE_GAP clock edges after the edge that took the byte. Bytes come out of buffer entries 0, 1, 2 and so on.
- R5: Write execution (0x05) shows status 0xB0 while DRQ is high. Each accepted byte is stored in the next buffer entry.
- R6: After DEPTH execution bytes the block enters a 7-byte result phase with status 0xD0 and IRQ=1. The bytes are ST0 = drive number (first parameter, bits 1:0), ST1 = 0x00, ST2, and then parameters 2 to 5.
- R7: Scan 0x11 misses when a disk byte differs from the host byte. Scan 0x19 misses when the disk byte is greater. Scan 0x1D misses when the disk byte is less. A host byte of 0xFF always matches. ST2 is 0x08 if there was no miss, otherwise 0x04.
- R8: If DRQ stays high for OVR_LIMIT cycles without service, DRQ drops and the block enters the 7-byte result phase with IRQ=1. In that case ST0 = 0x40 | drive and ST1 = 0x10.
- R9: Reading the last result byte returns the block to idle (status 0x80) and clears IRQ.
- R10: A pulse on `seek_done_i[d]` marks drive d pending and sets IRQ. Command 0x08 returns two bytes for the lowest pending drive, 0x20|d and then 0x00, and clears that drive's pending mark. IRQ stays set after the last byte while other drives are still pending. With nothing pending, it returns the single byte 0x80.
- R11: Specify (0x03) takes 2 parameters and returns to idle with no result phase and no IRQ.
- R12: Ready stays set through the parameter and result phases while bytes remain. The status is 0x90 while parameters are being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | 0 selects the status port, 1 selects the data port |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| drq_o | output | 1 | Per-byte execution request |
| irq_o | output | 1 | Interrupt request |
| seek_busy_i | input | 4 | Drive seek-busy bits merged into the status |
| seek_done_i | input | 4 | Seek-complete pulses, one bit per drive |
| ld_we_i | input | 1 | Buffer load write enable |
| ld_addr_i | input | $clog2(DEPTH) | Buffer load address |
| ld_data_i | input | 8 | Buffer load data |

## Verification
A wrong phase or a wrong count shows up in the very next status read, because ready, direction, execution and busy encode the phase directly. It also shows in the result bytes, which come right after the last execution byte. A buffer pointer that skips or repeats an entry shows up on the first byte that is off. Scan-direction errors and overrun errors show in ST0, ST1 and ST2 within seven reads of the end of the transfer. A pending-interrupt bookkeeping error shows in the sense-interrupt bytes and in the IRQ level after the last of them.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_e;
  typedef enum logic [2:0] {OP_BAD, OP_SPEC, OP_SENSE, OP_READ, OP_WRITE, OP_SCAN} op_e;

  typedef struct packed {
    op_e        op;
    logic [3:0] plen;
  } cmd_info_t;

  localparam int PAR_MAX = 8;
  localparam int RES_LEN = 7;

  localparam logic [7:0] ST0_INV  = 8'h80;
  localparam logic [7:0] ST0_ABN  = 8'h40;
  localparam logic [7:0] ST0_SEEK = 8'h20;
  localparam logic [7:0] ST1_OVR  = 8'h10;
  localparam logic [7:0] ST2_HIT  = 8'h08;
  localparam logic [7:0] ST2_MISS = 8'h04;

  localparam logic [4:0] CODE_SCAN_EQ = 5'h11;
  localparam logic [4:0] CODE_SCAN_LE = 5'h19;
endpackage

// File: rtl/fdc_cmd_table.sv
module fdc_cmd_table
  import fdc_pkg::*;
(
  input  logic [4:0] code_i,
  output cmd_info_t  info_o
);
  always_comb begin
    info_o.op   = OP_BAD;
    info_o.plen = 4'd0;
    unique case (code_i)
      5'h03: begin info_o.op = OP_SPEC;  info_o.plen = 4'd2; end
      5'h08: begin info_o.op = OP_SENSE; info_o.plen = 4'd0; end
      5'h06: begin info_o.op = OP_READ;  info_o.plen = 4'd8; end
      5'h05: begin info_o.op = OP_WRITE; info_o.plen = 4'd8; end
      5'h11, 5'h19, 5'h1D: begin info_o.op = OP_SCAN; info_o.plen = 4'd8; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fdc_xfer_timer.sv
module fdc_xfer_timer #(
  parameter int BYTE_GAP  = 4,
  parameter int OVR_LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic drq_i,
  output logic gap_done_o,
  output logic ovr_o
);
  localparam int GW = $clog2(BYTE_GAP + 1);
  localparam int OW = $clog2(OVR_LIMIT + 1);

  logic [GW-1:0] gap_q;
  logic [OW-1:0] ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gap_q <= '0;
    else if (start_i)       gap_q <= GW'(BYTE_GAP);
    else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ovr_q <= '0;
    else if (!drq_i)  ovr_q <= '0;
    else if (!ovr_o)  ovr_q <= ovr_q + 1'b1;
  end

  assign gap_done_o = (gap_q == GW'(1));
  assign ovr_o      = drq_i && (ovr_q == OW'(OVR_LIMIT - 1));
endmodule

// File: rtl/fdc_buf_ram.sv
module fdc_buf_ram #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [7:0]    ld_data_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i)         mem_q[waddr_i]   <= wdata_i;
    else if (ld_we_i) mem_q[ld_addr_i] <= ld_data_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
  import fdc_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int BYTE_GAP  = 4,
  parameter int OVR_LIMIT = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     addr_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [7:0]               wdata_i,
  output logic [7:0]               rdata_o,
  output logic                     drq_o,
  output logic                     irq_o,
  input  logic [3:0]               seek_busy_i,
  input  logic [3:0]               seek_done_i,
  input  logic                     ld_we_i,
  input  logic [$clog2(DEPTH)-1:0] ld_addr_i,
  input  logic [7:0]               ld_data_i
);
  localparam int AW   = $clog2(DEPTH);
  localparam int MAXN = (DEPTH > PAR_MAX) ? DEPTH : PAR_MAX;
  localparam int CW   = $clog2(MAXN + 1);

  phase_e        phase_q;
  op_e           op_q;
  logic [4:0]    code_q;
  logic          rqm_q, drq_q, irq_q, hit_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] ptr_q;
  logic [2:0]    idx_q;
  logic [3:0]    pend_q;
  logic [7:0]    par_q [PAR_MAX];
  logic [7:0]    res_q [RES_LEN];

  cmd_info_t  info;
  logic       dio, acc_wr, acc_rd, acc, last, start_gap, gap_done, ovr;
  logic       buf_we, miss_now, hit_nxt, any_pend;
  logic [1:0] sel_drv;
  logic [7:0] buf_dout, status, drv_b;

  fdc_cmd_table u_tbl (.code_i(wdata_i[4:0]), .info_o(info));

  fdc_xfer_timer #(.BYTE_GAP(BYTE_GAP), .OVR_LIMIT(OVR_LIMIT)) u_tmr (
    .clk_i, .rst_ni, .start_i(start_gap), .drq_i(drq_q),
    .gap_done_o(gap_done), .ovr_o(ovr)
  );

  fdc_buf_ram #(.DEPTH(DEPTH)) u_ram (
    .clk_i, .we_i(buf_we), .waddr_i(ptr_q), .wdata_i(wdata_i),
    .ld_we_i, .ld_addr_i, .ld_data_i, .raddr_i(ptr_q), .rdata_o(buf_dout)
  );

  assign dio    = (phase_q == PH_RES) || (phase_q == PH_EXEC && op_q == OP_READ);
  assign status = {rqm_q, dio, phase_q == PH_EXEC, phase_q != PH_IDLE, seek_busy_i};
  assign acc_wr = wr_i && addr_i && rqm_q && !dio;
  assign acc_rd = rd_i && addr_i && rqm_q && dio;
  assign acc    = acc_wr || acc_rd;
  assign last   = (cnt_q <= CW'(1));
  assign buf_we = (phase_q == PH_EXEC) && acc_wr && (op_q == OP_WRITE);
  assign start_gap = (phase_q == PH_EXEC) && acc && !last;
  assign drv_b  = {6'b0, par_q[0][1:0]};

  // scan compare, 0xFF from host is a wildcard
  always_comb begin
    miss_now = 1'b0;
    if (wdata_i != 8'hFF) begin
      if (code_q == CODE_SCAN_EQ)      miss_now = (buf_dout != wdata_i);
      else if (code_q == CODE_SCAN_LE) miss_now = (buf_dout > wdata_i);
      else                             miss_now = (buf_dout < wdata_i);
    end
  end
  assign hit_nxt = hit_q && !miss_now;

  // lowest pending drive
  always_comb begin
    sel_drv  = 2'd0;
    any_pend = 1'b0;
    for (int d = 3; d >= 0; d--) begin
      if (pend_q[d]) begin
        sel_drv  = 2'(d);
        any_pend = 1'b1;
      end
    end
  end

  always_comb begin
    if (!addr_i)     rdata_o = status;
    else if (acc_rd) rdata_o = (phase_q == PH_RES) ? res_q[idx_q] : buf_dout;
    else             rdata_o = 8'hFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_BAD;
      code_q  <= '0;
      rqm_q   <= 1'b1;
      drq_q   <= 1'b0;
      irq_q   <= 1'b0;
      hit_q   <= 1'b1;
      cnt_q   <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
      pend_q  <= '0;
      for (int i = 0; i < PAR_MAX; i++) par_q[i] <= '0;
      for (int i = 0; i < RES_LEN; i++) res_q[i] <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (acc_wr) begin
          code_q <= wdata_i[4:0];
          op_q   <= info.op;
          idx_q  <= '0;
          rqm_q  <= 1'b1;
          if (info.op == OP_BAD) begin
            res_q[0] <= ST0_INV;
            cnt_q    <= CW'(1);
            phase_q  <= PH_RES;
          end else if (info.op == OP_SENSE) begin
            phase_q <= PH_RES;
            if (any_pend) begin
              res_q[0] <= ST0_SEEK | {6'b0, sel_drv};
              res_q[1] <= 8'h00;
              cnt_q    <= CW'(2);
              pend_q[sel_drv] <= 1'b0;
            end else begin
              res_q[0] <= ST0_INV;
              cnt_q    <= CW'(1);
            end
          end else begin
            cnt_q   <= CW'(info.plen);
            phase_q <= PH_CMD;
          end
        end
        PH_CMD: if (acc_wr) begin
          par_q[idx_q] <= wdata_i;
          idx_q <= idx_q + 1'b1;
          rqm_q <= 1'b1;
          if (!last) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (op_q == OP_SPEC) begin
            phase_q <= PH_IDLE;
          end else begin
            phase_q <= PH_EXEC;
            cnt_q   <= CW'(DEPTH);
            ptr_q   <= '0;
            drq_q   <= 1'b1;
            hit_q   <= 1'b1;
          end
        end
        PH_EXEC: begin
          if (acc) begin
            drq_q <= 1'b0;
            rqm_q <= 1'b0;
            ptr_q <= ptr_q + 1'b1;
            if (op_q == OP_SCAN) hit_q <= hit_nxt;
            if (!last) begin
              cnt_q <= cnt_q - 1'b1;
            end else begin
              res_q[0] <= drv_b;
              res_q[1] <= 8'h00;
              res_q[2] <= (op_q != OP_SCAN) ? 8'h00 : (hit_nxt ? ST2_HIT : ST2_MISS);
              for (int i = 3; i < RES_LEN; i++) res_q[i] <= par_q[i-2];
              phase_q <= PH_RES;
              cnt_q   <= CW'(RES_LEN);
              idx_q   <= '0;
              rqm_q   <= 1'b1;
              irq_q   <= 1'b1;
            end
          end else if (ovr) begin
            drq_q    <= 1'b0;
            res_q[0] <= ST0_ABN | drv_b;
            res_q[1] <= ST1_OVR;
            res_q[2] <= 8'h00;
            for (int i = 3; i < RES_LEN; i++) res_q[i] <= par_q[i-2];
            phase_q <= PH_RES;
            cnt_q   <= CW'(RES_LEN);
            idx_q   <= '0;
            rqm_q   <= 1'b1;
            irq_q   <= 1'b1;
          end else if (gap_done) begin
            drq_q <= 1'b1;
            rqm_q <= 1'b1;
          end
        end
        PH_RES: if (acc_rd) begin
          idx_q <= idx_q + 1'b1;
          rqm_q <= 1'b1;
          if (!last) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            phase_q <= PH_IDLE;
            if (!(op_q == OP_SENSE && pend_q != '0)) irq_q <= 1'b0;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
      if (seek_done_i != '0) begin
        pend_q <= pend_q | seek_done_i;
        irq_q  <= 1'b1;
      end
    end
  end

  assign drq_o = drq_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/fdc_host_seq_chk.sv
module fdc_host_seq_chk
  import fdc_pkg::*;
#(
  parameter int CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          addr_i,
  input logic          wr_i,
  input phase_e        phase_i,
  input logic          rqm_i,
  input logic          dio_i,
  input logic          drq_i,
  input logic          irq_i,
  input logic          acc_i,
  input logic          ovr_i,
  input logic [CW-1:0] cnt_i
);
  logic ign_wr;
  assign ign_wr = wr_i && addr_i && !(rqm_i && !dio_i);

  assert_drq_exec_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drq_i |-> phase_i == PH_EXEC);

  assert_drq_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_EXEC && acc_i) |=> !drq_i);

  assert_ignored_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ign_wr && !ovr_i) |=> ($stable(phase_i) && $stable(cnt_i)));

  assert_overrun_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !acc_i) |=> (phase_i == PH_RES && !drq_i && irq_i));

  assert_idle_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PH_IDLE |-> (rqm_i && !dio_i));

  assert_result_ready_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_RES && acc_i && cnt_i > CW'(1)) |=> rqm_i);
endmodule

bind fdc_host_seq fdc_host_seq_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
  .phase_i(phase_q), .rqm_i(rqm_q), .dio_i(dio), .drq_i(drq_q),
  .irq_i(irq_q), .acc_i(acc), .ovr_i(ovr), .cnt_i(cnt_q)
);

// File: tb/sim_fdc_host_seq.sv
`timescale 1ns/1ps
module sim_fdc_host_seq;
  localparam int DEPTH = 16;
  localparam int GAP   = 4;
  localparam int OVR   = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       drq, irq;
  logic [3:0] seek_busy = '0, seek_done = '0;
  logic       ld_we = 1'b0;
  logic [3:0] ld_addr = '0;
  logic [7:0] ld_data = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  fdc_host_seq #(.DEPTH(DEPTH), .BYTE_GAP(GAP), .OVR_LIMIT(OVR)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .drq_o(drq), .irq_o(irq),
    .seek_busy_i(seek_busy), .seek_done_i(seek_done),
    .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_data_i(ld_data)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] d);
    @(negedge clk); addr = 1'b1; wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic host_rd(output logic [7:0] d);
    @(negedge clk); addr = 1'b1; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic rd_status(output logic [7:0] d);
    @(negedge clk); addr = 1'b0; #1 d = rdata;
  endtask

  task automatic wait_drq();
    for (int i = 0; i < 50 && !drq; i++) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] op, input logic [1:0] drv);
    host_wr(op);
    host_wr({6'b0, drv}); host_wr(8'h22); host_wr(8'h01); host_wr(8'h05);
    host_wr(8'h02); host_wr(8'h09); host_wr(8'h1B); host_wr(8'hFF);
  endtask

  task automatic read_results(input string req, input logic [7:0] s0,
                              input logic [7:0] s1, input logic [7:0] s2);
    logic [7:0] d;
    host_rd(d); check({req, " st0"}, d, s0);
    host_rd(d); check({req, " st1"}, d, s1);
    host_rd(d); check({req, " st2"}, d, s2);
    host_rd(d); check("R6 par2", d, 8'h22);
    host_rd(d); check("R6 par3", d, 8'h01);
    host_rd(d); check("R6 par4", d, 8'h05);
    host_rd(d); check("R6 par5", d, 8'h02);
    rd_status(d); check("R9 idle status", d, 8'h80);
    check("R9 irq cleared", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_status(d); check("R1 reset status", d, 8'h80);
    check("R1 reset drq/irq", {6'b0, drq, irq}, 8'h00);
    seek_busy = 4'h5;
    rd_status(d); check("R1 seek bits", d, 8'h85);
    seek_busy = 4'h0;
    host_rd(d); check("R2 read in idle", d, 8'hFF);
  endtask

  task automatic t_specify();
    logic [7:0] d;
    host_wr(8'h03);
    rd_status(d); check("R12 param status", d, 8'h90);
    host_wr(8'hAF);
    rd_status(d); check("R12 ready after param1", d, 8'h90);
    host_wr(8'h02);
    rd_status(d); check("R11 back to idle", d, 8'h80);
    check("R11 no irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_invalid();
    logic [7:0] d;
    host_wr(8'hE1);
    rd_status(d); check("R3 invalid status", d, 8'hD0);
    host_wr(8'h55);
    rd_status(d); check("R2 write refused in result", d, 8'hD0);
    host_rd(d); check("R3 invalid byte", d, 8'h80);
    rd_status(d); check("R3 idle after invalid", d, 8'h80);
  endtask

  task automatic t_read(input string req, input logic [7:0] base, input logic inv);
    logic [7:0] d;
    send_cmd(8'h46, 2'd1);
    wait_drq();
    rd_status(d); check("R4 read exec status", d, 8'hF0);
    host_wr(8'h33);
    rd_status(d); check("R2 write refused in read", d, 8'hF0);
    for (int i = 0; i < DEPTH; i++) begin
      wait_drq();
      host_rd(d);
      check(req, d, inv ? ~8'(i) : 8'(base + 8'(i * 7)));
      if (i == 0) begin
        check("R4 drq drop", {7'b0, drq}, 8'h00);
        rd_status(d); check("R4 ready drop", d, 8'h70);
        @(negedge clk); @(negedge clk);
        check("R4 drq still low", {7'b0, drq}, 8'h00);
        @(negedge clk);
        check("R4 drq after gap", {7'b0, drq}, 8'h01);
      end
    end
    rd_status(d); check("R6 result status", d, 8'hD0);
    check("R6 irq", {7'b0, irq}, 8'h01);
    read_results("R6", 8'h01, 8'h00, 8'h00);
  endtask

  task automatic t_write();
    logic [7:0] d;
    send_cmd(8'h05, 2'd2);
    wait_drq();
    rd_status(d); check("R5 write exec status", d, 8'hB0);
    host_rd(d); check("R2 read refused in write", d, 8'hFF);
    for (int i = 0; i < DEPTH; i++) begin
      wait_drq();
      host_wr(~8'(i));
    end
    read_results("R6 write", 8'h02, 8'h00, 8'h00);
    t_read("R5 stored bytes", 8'h00, 1'b1);
  endtask

  // disk holds ~i; host byte 2 is a wildcard; byte mi replaced by mv
  task automatic t_scan(input string req, input logic [7:0] op, input int mi,
                        input logic [7:0] mv, input logic [7:0] st2);
    send_cmd(op, 2'd0);
    for (int i = 0; i < DEPTH; i++) begin
      wait_drq();
      if (i == mi)     host_wr(mv);
      else if (i == 2) host_wr(8'hFF);
      else             host_wr(~8'(i));
    end
    read_results(req, 8'h00, 8'h00, st2);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    send_cmd(8'h06, 2'd3);
    wait_drq();
    repeat (OVR + 10) @(negedge clk);
    check("R8 drq dropped", {7'b0, drq}, 8'h00);
    rd_status(d); check("R8 result status", d, 8'hD0);
    check("R8 irq", {7'b0, irq}, 8'h01);
    read_results("R8", 8'h43, 8'h10, 8'h00);
  endtask

  task automatic t_sense();
    logic [7:0] d;
    host_wr(8'h08);
    host_rd(d); check("R10 nothing pending", d, 8'h80);
    @(negedge clk); seek_done = 4'b0110;
    @(negedge clk); seek_done = 4'b0000;
    check("R10 irq on seek", {7'b0, irq}, 8'h01);
    host_wr(8'h08);
    host_rd(d); check("R10 first drive", d, 8'h21);
    host_rd(d); check("R10 cyl", d, 8'h00);
    check("R10 irq held", {7'b0, irq}, 8'h01);
    host_wr(8'h08);
    host_rd(d); check("R10 second drive", d, 8'h22);
    host_rd(d); check("R10 cyl 2", d, 8'h00);
    check("R10 irq cleared", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); ld_we = 1'b1; ld_addr = 4'(i); ld_data = 8'(3 + i * 7);
    end
    @(negedge clk); ld_we = 1'b0;
    t_reset();
    t_specify();
    t_invalid();
    t_read("R4 read byte", 8'h03, 1'b0);
    t_write();
    t_scan("R7 eq hit wildcard", 8'h11, -1, 8'h00, 8'h08);
    t_scan("R7 eq miss", 8'h11, 4, 8'h00, 8'h04);
    t_scan("R7 le miss", 8'h19, 5, 8'h00, 8'h04);
    t_scan("R7 ge hit", 8'h1D, 5, 8'h00, 8'h08);
    t_scan("R7 ge miss", 8'h1D, 5, 8'hFE, 8'h04);
    t_overrun();
    t_sense();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule